// File: doc/BRIEF.md
# Background Flash Streaming Read Engine

This block copies a linear run of 32-bit words from flash into a two-word holding FIFO, in the background. Software loads a word-aligned start address and a word count. A nonzero count starts the transfer. The engine then raises one read request at a time toward the flash interface, and only in cycles when the flash interface reports that it is otherwise idle. Each granted request advances the address by one word and lowers the count by one. The engine stops by itself once the count reaches zero.

Returned words are pushed into the FIFO. A consumer such as a DMA channel drains the FIFO through a pop port, and the empty and full flags together give the fill level. The engine never issues a read unless the FIFO has room for its data, counting the word still in flight. While the FIFO is full, the stream therefore pauses rather than losing data.

Writing a zero count aborts a running stream. Each request carries a one-bit epoch tag, and the flash side returns that tag with the response. An abort flips the epoch, so a response to a read issued before the abort is recognised as stale and discarded. A new stream can therefore be programmed straight after an abort without waiting for the old read to finish.

Top module: `flash_stream_engine`

## Requirements
- R1: After reset the count and address read back as 0, the FIFO is empty (empty=1, full=0) and no read is requested.
- R2: The address register keeps only bits 31:2. Bits 1:0 of a written address are ignored, and `addr_q` and `rd_addr` always read back with bits 1:0 equal to 0.
- R3: `rd_req` is high only when all of these hold: the count is nonzero, `flash_idle` is 1, no read is pending, and the FIFO is not full.
- R4: Each cycle with `rd_req` and `rd_gnt` both high adds 4 to the address and subtracts 1 from the count. When the count reaches 0, no further request is made.
- R5: At most one read is outstanding. After a granted request, `rd_req` stays low until the matching response arrives or the stream is aborted.
- R6: A response with `rsp_tag` equal to the current `rd_tag` is pushed into the FIFO. Words are popped in the order in which they were requested.
- R7: Writing 0 to the count clears it, inverts `rd_tag`, and drops the pending read. A later response carrying the old tag never enters the FIFO.
- R8: `fifo_empty` is 1 exactly when the FIFO holds 0 words, and `fifo_full` is 1 exactly when it holds 2 words.
- R9: Popping an empty FIFO returns `pop_data` of 0 and leaves the FIFO empty, with no underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr_we | input | 1 | Load the start address |
| cfg_addr_wdata | input | 32 | Start address; bits 1:0 are ignored |
| cfg_cnt_we | input | 1 | Load the word count; a zero value aborts |
| cfg_cnt_wdata | input | CNT_W | Word count |
| addr_q | output | 32 | Live address of the next word |
| cnt_q | output | CNT_W | Live remaining count |
| flash_idle | input | 1 | Flash interface has no other traffic |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read address |
| rd_tag | output | 1 | Epoch tag of the request |
| rd_gnt | input | 1 | Request accepted this cycle |
| rsp_valid | input | 1 | Read data returned |
| rsp_tag | input | 1 | Epoch tag echoed with the data |
| rsp_data | input | 32 | Returned word |
| pop | input | 1 | Remove the head word of the FIFO |
| pop_data | output | 32 | Head word, or 0 when empty |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_full | output | 1 | FIFO holds two words |

## Verification
The assertions assume that the flash side returns responses in request order, and that it sends a response only for a request it has granted, carrying the tag that the request had when it was granted. The bench's flash model records each granted request together with its address and tag, and then answers from that ordered record after random delays. It therefore never produces a response that was not requested. The grant and idle inputs, and the consumer's pops, are otherwise random. This lets backpressure, stalls and aborts occur in arbitrary cycles while the flash side still respects the ordering the checks depend on.

// File: rtl/flash_stream_engine.sv
module flash_stream_engine #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_addr_we,
  input  logic [31:0]      cfg_addr_wdata,
  input  logic             cfg_cnt_we,
  input  logic [CNT_W-1:0] cfg_cnt_wdata,
  output logic [31:0]      addr_q,
  output logic [CNT_W-1:0] cnt_q,
  input  logic             flash_idle,
  output logic             rd_req,
  output logic [31:0]      rd_addr,
  output logic             rd_tag,
  input  logic             rd_gnt,
  input  logic             rsp_valid,
  input  logic             rsp_tag,
  input  logic [31:0]      rsp_data,
  input  logic             pop,
  output logic [31:0]      pop_data,
  output logic             fifo_empty,
  output logic             fifo_full
);

  localparam int WORD_W = 30;
  localparam logic [1:0] FULL_LVL = 2'd2;

  logic [WORD_W-1:0] word_addr;
  logic [CNT_W-1:0]  remaining;
  logic              pending;
  logic              epoch;
  logic [31:0]       slot [2];
  logic              wr_ptr, rd_ptr;
  logic [1:0]        level;

  logic issue, abort, accept, take;

  assign abort  = cfg_cnt_we && (cfg_cnt_wdata == '0);
  assign issue  = rd_req && rd_gnt;
  assign accept = rsp_valid && pending && (rsp_tag == epoch) && !abort;
  assign take   = pop && (level != 2'd0);

  assign rd_req = (remaining != '0) && !pending && flash_idle && (level != FULL_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_addr <= '0;
    end else if (cfg_addr_we) begin
      word_addr <= cfg_addr_wdata[31:2];
    end else if (issue) begin
      word_addr <= word_addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (cfg_cnt_we) begin
      remaining <= cfg_cnt_wdata;
    end else if (issue) begin
      remaining <= remaining - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      epoch   <= 1'b0;
    end else begin
      if (abort) begin
        epoch <= ~epoch;
      end
      if (abort || accept) begin
        pending <= 1'b0;
      end else if (issue) begin
        pending <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      slot[wr_ptr] <= rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= 1'b0;
      rd_ptr <= 1'b0;
      level  <= 2'd0;
    end else begin
      if (accept) begin
        wr_ptr <= ~wr_ptr;
      end
      if (take) begin
        rd_ptr <= ~rd_ptr;
      end
      if (accept && !take) begin
        level <= level + 2'd1;
      end else if (take && !accept) begin
        level <= level - 2'd1;
      end
    end
  end

  assign addr_q     = {word_addr, 2'b00};
  assign rd_addr    = {word_addr, 2'b00};
  assign rd_tag     = epoch;
  assign cnt_q      = remaining;
  assign fifo_empty = (level == 2'd0);
  assign fifo_full  = (level == FULL_LVL);
  assign pop_data   = fifo_empty ? 32'd0 : slot[rd_ptr];

endmodule
// File: rtl/flash_stream_engine_checks.sv
module flash_stream_engine_checks #(
  parameter int CNT_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_addr_we,
  input logic [31:0]      cfg_addr_wdata,
  input logic             cfg_cnt_we,
  input logic [CNT_W-1:0] cfg_cnt_wdata,
  input logic [31:0]      addr_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flash_idle,
  input logic             rd_req,
  input logic             rd_tag,
  input logic             rd_gnt,
  input logic             pop,
  input logic [31:0]      pop_data,
  input logic             fifo_empty,
  input logic             fifo_full
);

  a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr_we |=> addr_q == {$past(cfg_addr_wdata[31:2]), 2'b00});

  a_r3_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (flash_idle && !fifo_full && cnt_q != '0));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_gnt && !cfg_addr_we && !cfg_cnt_we) |=>
      (cnt_q == $past(cnt_q) - 1'b1) && (addr_q == $past(addr_q) + 32'd4));

  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_gnt) |=> !rd_req);

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cnt_we && cfg_cnt_wdata == '0) |=>
      (cnt_q == '0) && (rd_tag != $past(rd_tag)) && !rd_req);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));

  a_r8_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> !fifo_empty);

  a_r9_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fifo_empty) |-> pop_data == 32'd0);

  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fifo_empty) |=> !fifo_full);

endmodule

bind flash_stream_engine flash_stream_engine_checks #(.CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst_n(rst_n),
  .cfg_addr_we(cfg_addr_we), .cfg_addr_wdata(cfg_addr_wdata),
  .cfg_cnt_we(cfg_cnt_we), .cfg_cnt_wdata(cfg_cnt_wdata),
  .addr_q(addr_q), .cnt_q(cnt_q), .flash_idle(flash_idle),
  .rd_req(rd_req), .rd_tag(rd_tag), .rd_gnt(rd_gnt),
  .pop(pop), .pop_data(pop_data),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full)
);
// File: tb/flash_stream_engine_test.sv
module flash_stream_engine_test;
  localparam int CNT_W = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_addr_we = 1'b0;
  logic [31:0] cfg_addr_wdata = '0;
  logic cfg_cnt_we = 1'b0;
  logic [CNT_W-1:0] cfg_cnt_wdata = '0;
  logic [31:0] addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic flash_idle = 1'b0;
  logic rd_req;
  logic [31:0] rd_addr;
  logic rd_tag;
  logic rd_gnt = 1'b0;
  logic rsp_valid = 1'b0;
  logic rsp_tag = 1'b0;
  logic [31:0] rsp_data = '0;
  logic pop = 1'b0;
  logic [31:0] pop_data;
  logic fifo_empty, fifo_full;

  flash_stream_engine #(.CNT_W(CNT_W)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int idle_mode = 0;
  bit hold_rsp = 1'b0;
  logic [32:0] fq [16];
  int qh = 0, qt = 0;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    case (idle_mode)
      1: flash_idle = 1'b1;
      2: flash_idle = 1'b0;
      default: flash_idle = ($urandom % 4) != 0;
    endcase
    rd_gnt = ($urandom % 3) != 0;
    if (qt != qh && !hold_rsp && ($urandom % 3) == 0) begin
      rsp_valid = 1'b1;
      rsp_tag   = fq[qh % 16][32];
      rsp_data  = word_of(fq[qh % 16][31:0]);
    end else begin
      rsp_valid = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (rst_n && rd_req && rd_gnt) begin
      fq[qt % 16] = {rd_tag, rd_addr};
      qt++;
    end
    if (rsp_valid) qh++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr_addr(input logic [31:0] a);
    @(negedge clk); cfg_addr_we = 1'b1; cfg_addr_wdata = a;
    @(negedge clk); cfg_addr_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [CNT_W-1:0] c);
    @(negedge clk); cfg_cnt_we = 1'b1; cfg_cnt_wdata = c;
    @(negedge clk); cfg_cnt_we = 1'b0;
  endtask

  task automatic consume(input logic [31:0] start, input int n);
    logic [31:0] exp = start;
    int got = 0;
    int guard = 0;
    while (got < n && guard < 4000) begin
      @(negedge clk);
      pop = 1'b0;
      guard++;
      if (!fifo_empty && ($urandom % 2) == 0) begin
        check(pop_data == word_of(exp), "R6 order", pop_data, word_of(exp));
        exp += 32'd4;
        got++;
        pop = 1'b1;
      end
    end
    @(negedge clk); pop = 1'b0;
    check(got == n, "R6 word count", got, n);
  endtask

  task automatic run_stream(input logic [31:0] start, input int n);
    wr_addr(start);
    wr_cnt(n[CNT_W-1:0]);
    consume(start, n);
    repeat (20) @(negedge clk);
    check(cnt_q == '0, "R4 count at end", cnt_q, 0);
    check(addr_q == start + 32'(4 * n), "R4 address at end", addr_q, start + 32'(4 * n));
    check(fifo_empty && !rd_req, "R4 halted", {fifo_empty, rd_req}, 2'b10);
  endtask

  initial begin
    logic old_tag;
    int snap;
    repeat (3) @(negedge clk);
    check(cnt_q == '0 && addr_q == '0, "R1 regs", addr_q, 0);
    check(fifo_empty && !fifo_full && !rd_req, "R1 flags", {fifo_empty, fifo_full, rd_req}, 3'b100);
    rst_n = 1'b1;

    wr_addr(32'h1234_5677);
    check(addr_q == 32'h1234_5674 && rd_addr[1:0] == 2'b00, "R2 alignment", addr_q, 32'h1234_5674);

    idle_mode = 1;
    repeat (10) @(negedge clk);
    check(!rd_req && qt == 0, "R3 zero count no request", rd_req, 0);

    idle_mode = 2;
    wr_cnt(22'd4);
    snap = qt;
    repeat (30) @(negedge clk);
    check(qt == snap && cnt_q == 22'd4, "R3 busy flash blocks", cnt_q, 4);
    idle_mode = 0;
    consume(32'h1234_5674, 4);

    pop = 1'b1; #1;
    check(pop_data == 32'd0, "R9 empty pop data", pop_data, 0);
    @(negedge clk); pop = 1'b0;
    check(fifo_empty && !fifo_full, "R9 still empty", {fifo_empty, fifo_full}, 2'b10);

    idle_mode = 1;
    wr_addr(32'h0000_0100);
    wr_cnt(22'd5);
    repeat (60) @(negedge clk);
    check(fifo_full && !fifo_empty, "R8 full flag", {fifo_full, fifo_empty}, 2'b10);
    check(!rd_req, "R3 no request when full", rd_req, 0);
    check(cnt_q == 22'd3, "R4 two issued", cnt_q, 3);
    check(pop_data == word_of(32'h100), "R6 head word", pop_data, word_of(32'h100));
    pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    check(!fifo_full && !fifo_empty, "R8 one word", {fifo_full, fifo_empty}, 2'b00);
    consume(32'h0000_0104, 4);
    repeat (10) @(negedge clk);
    check(qt == qh, "R6 flash drained", qt - qh, 0);

    hold_rsp = 1'b1;
    wr_addr(32'h0000_8000);
    snap = qt;
    wr_cnt(22'd10);
    while (qt == snap) @(negedge clk);
    old_tag = rd_tag;
    wr_cnt(22'd0);
    check(cnt_q == '0, "R7 count cleared", cnt_q, 0);
    check(rd_tag != old_tag, "R7 tag flips", rd_tag, ~old_tag);
    hold_rsp = 1'b0;
    while (qt != qh) @(negedge clk);
    repeat (5) @(negedge clk);
    check(fifo_empty, "R7 stale dropped", fifo_empty, 1);

    hold_rsp = 1'b1;
    wr_addr(32'h0000_9000);
    snap = qt;
    wr_cnt(22'd6);
    while (qt == snap) @(negedge clk);
    wr_cnt(22'd0);
    wr_addr(32'h0000_A000);
    wr_cnt(22'd7);
    hold_rsp = 1'b0;
    consume(32'h0000_A000, 7);
    check(cnt_q == '0, "R7 restart completes", cnt_q, 0);

    idle_mode = 0;
    for (int i = 0; i < 8; i++) begin
      run_stream({$urandom} & 32'hFFFF_FFFC, 1 + ($urandom % 24));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule